// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the message table and the pending-bit array for a function that signals interrupts as memory writes. Logic inside the chip raises a request naming a vector. The block checks whether that vector is in use and whether it is masked. It then either places the vector's stored address and data on a single message output, or it records the request as a pending bit. Software reaches the table and the pending array through a 32-bit register port with word granularity. The two capability control bits, global enable and function mask, are written over a separate narrow port and read back as a 16-bit control word.

Pending vectors are replayed when their mask is lifted. When a table write clears a vector's own mask bit, the vector is replayed from the idle output. When a control write changes the function-level mask, a sweep visits every vector in index order, one per clock, and keeps `busy` high until it finishes. While `busy` is high, requests, table writes and control writes are discarded. The agent that uses the block tracks how many users hold each vector through increment and decrement strobes. A vector whose use count is zero cannot raise a message.

Top module: `msix_vec_ctrl`

## Requirements
- R1: Each vector owns 16 bytes of the table space, at byte address `16*v`. Word 0 is the low half of the message address and word 1 is the high half. Word 2 is the message data. In word 3, bit 0 is the vector's mask bit, and every other bit reads as 0. Words at vectors `v >= NVEC` read as 0 and ignore writes.
- R2: After reset the table words read 0, every vector's mask bit reads 1, the pending array reads 0, enable and function mask are 0, every use count is 0, and `busy` and `msg_valid` are low.
- R3: `cfg_rdata` carries enable in bit 15 and function mask in bit 14. Bits 10:0 carry NVEC-1, and all other bits are 0. A `cfg_wr` loads enable from `cfg_wbits[1]` and function mask from `cfg_wbits[0]`.
- R4: The pending bit of vector v is bit `v mod 32` of pending word `v div 32`, at byte address `4*(v div 32)`. The array spans NVEC rounded up to a multiple of 64 bits, and unused bits read 0. Writes to the pending array change nothing.
- R5: A request is dropped with no message and no pending bit when its vector is `>= NVEC` or when the vector's use count is zero.
- R6: A vector is masked when enable is 0, when function mask is 1, or when its own mask bit is 1. A request for a masked vector sets its pending bit and sends nothing.
- R7: When the output is free and no pending vector is waiting, a request for an unmasked vector raises `msg_valid` on the following clock. The message carries that vector's 64-bit address and 32-bit data.
- R8: A message stays on the output with stable address and data until `msg_ready`. A request for an unmasked vector that arrives while the output is occupied sets the pending bit instead. Pending unmasked vectors are sent later, lowest index first.
- R9: When a table write clears the mask bit of a pending vector while the function is unmasked, the block sends that vector's message and clears its pending bit.
- R10: A control write that changes the function-level mask while leaving enable at 1 raises `busy` for NVEC cycles, or longer if the output stalls. During that time every vector whose pending bit is set and which is now unmasked is sent, in index order. Requests, table writes and control writes presented while `busy` is high are ignored.
- R11: `use_inc` and `use_dec` raise or lower the use count of `use_vec`. The count saturates at its maximum, and a decrement at zero has no effect. A decrement that brings a count to zero clears that vector's pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the control bits |
| cfg_wbits | input | 2 | {enable, function mask} to load |
| cfg_rdata | output | 16 | Control word readback |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_pba | input | 1 | 1 = pending array, 0 = table |
| acc_addr | input | RA_W | Byte address, word aligned |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational) |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | VIDX_W | Requested vector |
| use_inc | input | 1 | Increment use count |
| use_dec | input | 1 | Decrement use count |
| use_vec | input | VIDX_W | Vector whose count changes |
| busy | output | 1 | Mask sweep in progress |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The hardest state to reach is a set of pending vectors that become sendable all at once. This happens when the output is held back or when the function mask is lifted, and the replay order then depends on index order. The bench gets there by holding `msg_ready` low while it fires requests at several vectors. It then releases the output and checks the order of the delivered messages. It also parks requests under the function mask and then clears the mask, so that the sweep replays them. While `busy` is high it presents a request and a table write, and then checks through the pending array and the table that both left no trace.

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl #(
  parameter int NVEC   = 40,
  parameter int VIDX_W = 8,
  parameter int CNT_W  = 4,
  parameter int RA_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_wbits,
  output logic [15:0]       cfg_rdata,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_pba,
  input  logic [RA_W-1:0]   acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic              irq_valid,
  input  logic [VIDX_W-1:0] irq_vec,
  input  logic              use_inc,
  input  logic              use_dec,
  input  logic [VIDX_W-1:0] use_vec,
  output logic              busy,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam int SW        = (NVEC > 1) ? $clog2(NVEC) : 1;
  localparam int PBA_W     = ((NVEC + 63) / 64) * 64;
  localparam int PBA_WORDS = PBA_W / 32;
  localparam logic [10:0] QSZ = 11'(NVEC - 1);

  logic [31:0]      t_alo [NVEC];
  logic [31:0]      t_ahi [NVEC];
  logic [31:0]      t_dat [NVEC];
  logic [CNT_W-1:0] ucnt  [NVEC];
  logic [NVEC-1:0]  vmask, pend, used;
  logic             en_q, fm_q;
  logic             sweep_on;
  logic [SW-1:0]    sweep_idx;

  wire fmasked = !en_q || fm_q;
  wire [NVEC-1:0] vmasked = vmask | {NVEC{fmasked}};
  assign busy = sweep_on;
  assign cfg_rdata = {en_q, fm_q, 3'b000, QSZ};

  for (genvar v = 0; v < NVEC; v++) begin : g_used
    assign used[v] = (ucnt[v] != '0);
  end

  wire                a_align = (acc_addr[1:0] == 2'b00);
  wire [RA_W-5:0]     a_vec   = acc_addr[RA_W-1:4];
  wire [SW-1:0]       a_vi    = a_vec[SW-1:0];
  wire [1:0]          a_fld   = acc_addr[3:2];
  wire                a_tab   = !acc_pba && a_align && ({1'b0, a_vec} < NVEC[RA_W-4:0]);
  wire [RA_W-3:0]     a_pw    = acc_addr[RA_W-1:2];
  wire                a_pok   = acc_pba && a_align && ({1'b0, a_pw} < PBA_WORDS[RA_W-2:0]);
  wire                tab_wr  = acc_en && acc_wr && !busy && a_tab;

  logic [PBA_W-1:0] pba_vec;
  always_comb begin
    pba_vec = '0;
    pba_vec[NVEC-1:0] = pend;
  end

  always_comb begin
    acc_rdata = '0;
    if (a_pok) acc_rdata = pba_vec[32*int'(a_pw) +: 32];
    else if (a_tab) begin
      case (a_fld)
        2'd0:    acc_rdata = t_alo[a_vi];
        2'd1:    acc_rdata = t_ahi[a_vi];
        2'd2:    acc_rdata = t_dat[a_vi];
        default: acc_rdata = {31'd0, vmask[a_vi]};
      endcase
    end
  end

  wire [SW-1:0] rq_i  = irq_vec[SW-1:0];
  wire          rq_ok = irq_valid && !busy && ({1'b0, irq_vec} < NVEC[VIDX_W:0]) && used[rq_i];

  wire [SW-1:0] u_i   = use_vec[SW-1:0];
  wire          u_ok  = ({1'b0, use_vec} < NVEC[VIDX_W:0]);
  wire          u_inc = use_inc && !use_dec && u_ok && (ucnt[u_i] != '1);
  wire          u_dec = use_dec && !use_inc && u_ok && (ucnt[u_i] != '0);
  wire          u_clr = u_dec && (ucnt[u_i] == CNT_W'(1));

  wire          slot_free = !msg_valid || msg_ready;
  wire [NVEC-1:0] ready_v = pend & ~vmasked;

  logic          dr_hit;
  logic [SW-1:0] dr_i;
  always_comb begin
    dr_hit = 1'b0;
    dr_i   = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (ready_v[i]) begin
        dr_hit = 1'b1;
        dr_i   = SW'(i);
      end
    end
  end

  wire sw_hit  = pend[sweep_idx] && !vmasked[sweep_idx];
  wire sw_step = sweep_on && (!sw_hit || slot_free);
  wire rq_send = !sweep_on && slot_free && !dr_hit && rq_ok && !vmasked[rq_i];
  wire rq_park = rq_ok && !rq_send;

  logic          ld, ld_pend;
  logic [SW-1:0] ld_i;
  always_comb begin
    ld = 1'b0; ld_pend = 1'b0; ld_i = '0;
    if (sweep_on) begin
      if (sw_hit && slot_free) begin ld = 1'b1; ld_pend = 1'b1; ld_i = sweep_idx; end
    end else if (slot_free && dr_hit) begin
      ld = 1'b1; ld_pend = 1'b1; ld_i = dr_i;
    end else if (rq_send) begin
      ld = 1'b1; ld_i = rq_i;
    end
  end

  wire new_fm = !cfg_wbits[1] || cfg_wbits[0];
  wire cfg_go = cfg_wr && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NVEC; i++) begin
        t_alo[i] <= '0; t_ahi[i] <= '0; t_dat[i] <= '0; ucnt[i] <= '0;
      end
      vmask     <= '1;
      pend      <= '0;
      en_q      <= 1'b0;
      fm_q      <= 1'b0;
      sweep_on  <= 1'b0;
      sweep_idx <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      if (tab_wr) begin
        case (a_fld)
          2'd0:    t_alo[a_vi] <= acc_wdata;
          2'd1:    t_ahi[a_vi] <= acc_wdata;
          2'd2:    t_dat[a_vi] <= acc_wdata;
          default: vmask[a_vi] <= acc_wdata[0];
        endcase
      end

      if (u_inc) ucnt[u_i] <= ucnt[u_i] + 1'b1;
      if (u_dec) ucnt[u_i] <= ucnt[u_i] - 1'b1;

      begin
        logic [NVEC-1:0] pn;
        pn = pend;
        if (ld_pend) pn[ld_i] = 1'b0;
        if (rq_park) pn[rq_i] = 1'b1;
        if (u_clr)   pn[u_i]  = 1'b0;
        pend <= pn;
      end

      if (cfg_go) begin
        en_q <= cfg_wbits[1];
        fm_q <= cfg_wbits[0];
        if (cfg_wbits[1] && (new_fm != fmasked)) begin
          sweep_on  <= 1'b1;
          sweep_idx <= '0;
        end
      end else if (sw_step) begin
        if (sweep_idx == SW'(NVEC - 1)) sweep_on <= 1'b0;
        else sweep_idx <= sweep_idx + 1'b1;
      end

      if (ld) begin
        msg_valid <= 1'b1;
        msg_addr  <= {t_ahi[ld_i], t_alo[ld_i]};
        msg_data  <= t_dat[ld_i];
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msix_vec_ctrl_chk.sv
module msix_vec_ctrl_chk #(
  parameter int NVEC = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic [15:0]     cfg_rdata,
  input logic            busy,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [63:0]     msg_addr,
  input logic [31:0]     msg_data,
  input logic [NVEC-1:0] pend,
  input logic [NVEC-1:0] used
);
  p_msg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_masked_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(cfg_rdata[15] && !cfg_rdata[14]));

  p_pend_used_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~used) == '0);

  p_sweep_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_wr));
endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata), .busy(busy),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data), .pend(pend), .used(used)
);

// File: tb/tb_msix_vec_ctrl.sv
`timescale 1ns/1ps
module tb_msix_vec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_wbits = '0;
  logic [15:0] cfg_rdata;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_pba = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic        irq_valid = 1'b0;
  logic [7:0]  irq_vec = '0;
  logic        use_inc = 1'b0, use_dec = 1'b0;
  logic [7:0]  use_vec = '0;
  logic        busy, msg_valid;
  logic        msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  always #4 clk = ~clk;

  msix_vec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wbits(cfg_wbits), .cfg_rdata(cfg_rdata),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_pba(acc_pba), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec), .busy(busy),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int n_tests = 0, n_fail = 0;
  int log_n = 0;
  logic [31:0] log_d [32];
  logic [63:0] log_a [32];

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready && log_n < 32) begin
      log_d[log_n] <= msg_data;
      log_a[log_n] <= msg_addr;
      log_n <= log_n + 1;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, int addr, logic [31:0] d);
    @(negedge clk);
    acc_pba = sel; acc_addr = 12'(addr); acc_wdata = d; acc_en = 1'b1; acc_wr = 1'b1;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(logic sel, int addr, output logic [31:0] d);
    @(negedge clk);
    acc_pba = sel; acc_addr = 12'(addr); acc_en = 1'b1; acc_wr = 1'b0;
    #1 d = acc_rdata;
    acc_en = 1'b0;
  endtask

  task automatic cfg(logic [1:0] b);
    @(negedge clk);
    cfg_wbits = b; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic req(int v);
    @(negedge clk);
    irq_valid = 1'b1; irq_vec = 8'(v);
    @(negedge clk);
    irq_valid = 1'b0;
  endtask

  task automatic use_op(logic inc, logic dec, int v);
    @(negedge clk);
    use_inc = inc; use_dec = dec; use_vec = 8'(v);
    @(negedge clk);
    use_inc = 1'b0; use_dec = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_free();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R2 cfg", cfg_rdata, 16'h0027);
    check("R3 size", cfg_rdata[10:0], 39);
    rd(0, 0*16 + 12, d); check("R2 mask v0", d, 1);
    rd(0, 39*16 + 12, d); check("R2 mask v39", d, 1);
    rd(0, 39*16, d); check("R2 alo v39", d, 0);
    rd(1, 0, d); check("R2 pba w0", d, 0);
    rd(1, 4, d); check("R2 pba w1", d, 0);
    check("R2 busy/valid", {busy, msg_valid}, 0);
  endtask

  task automatic t_table();
    logic [31:0] d;
    wr(0, 5*16, 32'hFEE0_0050); wr(0, 5*16 + 4, 1); wr(0, 5*16 + 8, 32'h4105);
    wr(0, 5*16 + 12, 32'hFFFF_FFFF);
    rd(0, 5*16 + 12, d); check("R1 ctrl only bit0", d, 1);
    wr(0, 5*16 + 12, 32'hFFFF_FFFE);
    rd(0, 5*16 + 12, d); check("R1 ctrl cleared", d, 0);
    rd(0, 5*16 + 4, d); check("R1 addr hi", d, 1);
    rd(0, 5*16 + 8, d); check("R1 data", d, 32'h4105);
    wr(0, 3*16, 32'hFEE0_0030); wr(0, 3*16 + 8, 32'h33); wr(0, 3*16 + 12, 0);
    wr(0, 6*16, 32'hFEE0_0060); wr(0, 6*16 + 8, 32'h66); wr(0, 6*16 + 12, 0);
    wr(0, 35*16, 32'hFEE0_0350); wr(0, 35*16 + 8, 32'h3535); wr(0, 35*16 + 12, 0);
    wr(0, 40*16, 32'h1234_5678);
    rd(0, 40*16, d); check("R1 out of range", d, 0);
  endtask

  task automatic t_enable();
    int n = 0;
    cfg(2'b10);
    while (busy) begin n++; @(negedge clk); end
    check("R10 sweep length", n, 40);
    check("R3 enable bit", cfg_rdata, 16'h8027);
  endtask

  task automatic t_drop();
    logic [31:0] d;
    int b = log_n;
    req(5); idle(3);
    check("R5 unused vector no msg", log_n, b);
    rd(1, 0, d); check("R5 unused no pend", d, 0);
    use_op(1, 0, 5); use_op(1, 0, 3); use_op(1, 0, 6); use_op(1, 0, 35);
    req(40); req(200); idle(3);
    check("R5 out of range no msg", log_n, b);
    rd(1, 0, d); check("R5 out of range no pend w0", d, 0);
    rd(1, 4, d); check("R5 out of range no pend w1", d, 0);
  endtask

  task automatic t_send();
    int b = log_n;
    req(5);
    check("R7 valid next cycle", msg_valid, 1);
    check("R7 addr", msg_addr, 64'h1_FEE0_0050);
    check("R7 data", msg_data, 32'h4105);
    idle(2);
    check("R7 one message", log_n, b + 1);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    int b = log_n;
    wr(0, 5*16 + 12, 1);
    req(5); idle(3);
    check("R6 masked no msg", log_n, b);
    rd(1, 0, d); check("R6 pend set", d, 32'h20);
    wr(1, 0, 0);
    rd(1, 0, d); check("R4 pba write ignored", d, 32'h20);
  endtask

  task automatic t_unmask();
    logic [31:0] d;
    int b = log_n;
    wr(0, 5*16 + 12, 0);
    idle(3);
    check("R9 replay count", log_n, b + 1);
    check("R9 replay data", log_d[b], 32'h4105);
    rd(1, 0, d); check("R9 pend cleared", d, 0);
  endtask

  task automatic t_stall();
    logic [31:0] d;
    int b = log_n;
    msg_ready = 1'b0;
    req(6);
    check("R8 stalled msg data", msg_data, 32'h66);
    req(5); req(3);
    rd(1, 0, d); check("R8 parked as pending", d, 32'h28);
    idle(2);
    check("R8 held stable", {msg_valid, msg_data}, {1'b1, 32'h66});
    msg_ready = 1'b1;
    idle(5);
    check("R8 count", log_n, b + 3);
    check("R8 first", log_d[b], 32'h66);
    check("R8 lowest pending next", log_d[b + 1], 32'h33);
    check("R8 then", log_d[b + 2], 32'h4105);
    check("R8 addr of v3", log_a[b + 1], 64'hFEE0_0030);
  endtask

  task automatic t_vec35();
    logic [31:0] d;
    cfg(2'b11); wait_free();
    check("R3 fmask bit", cfg_rdata, 16'hC027);
    req(35); idle(2);
    rd(1, 4, d); check("R4 v35 in word1 bit3", d, 32'h8);
    rd(1, 0, d); check("R4 word0 clear", d, 0);
  endtask

  task automatic t_sweep();
    logic [31:0] d;
    int b;
    req(5); idle(2);
    rd(1, 0, d); check("R6 fmask parks", d, 32'h20);
    b = log_n;
    cfg(2'b10);
    check("R10 busy", busy, 1);
    irq_valid = 1'b1; irq_vec = 8'd6;
    acc_pba = 1'b0; acc_addr = 12'(6*16 + 8); acc_wdata = 32'h99; acc_en = 1'b1; acc_wr = 1'b1;
    cfg_wbits = 2'b11; cfg_wr = 1'b1;
    @(negedge clk);
    irq_valid = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; cfg_wr = 1'b0;
    wait_free(); idle(2);
    check("R10 sweep sent", log_n, b + 2);
    check("R10 order first", log_d[b], 32'h4105);
    check("R10 order second", log_d[b + 1], 32'h3535);
    rd(1, 0, d); check("R10 req ignored while busy", d, 0);
    rd(1, 4, d); check("R10 w1 cleared", d, 0);
    rd(0, 6*16 + 8, d); check("R10 write ignored while busy", d, 32'h66);
    check("R10 cfg write ignored while busy", cfg_rdata, 16'h8027);
  endtask

  task automatic t_use();
    logic [31:0] d;
    cfg(2'b11); wait_free();
    req(3); idle(1);
    rd(1, 0, d); check("R11 pend before", d, 32'h8);
    use_op(0, 1, 3);
    rd(1, 0, d); check("R11 count zero clears pend", d, 0);
    use_op(0, 1, 3);
    use_op(1, 0, 3);
    req(3); idle(1);
    rd(1, 0, d); check("R11 dec at zero ignored", d, 32'h8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_table();
    t_enable();
    t_drop();
    t_send();
    t_masked();
    t_unmask();
    t_stall();
    t_vec35();
    t_sweep();
    t_use();
    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule